// File: doc/BRIEF.md
# Two-Stage Thermal Output Shedder

This block protects a chip's output drivers from overheating. It takes an 8-bit die temperature code, which arrives with a sample-valid strobe, and compares it with three programmable levels: a first trip level, a second trip level and a lower resume level. The block drives one disable line for each digital, current and voltage output channel, and a single overtemperature flag that a status register can capture.

At the first trip level, the block switches off only the channels whose driver reports that it cannot saturate, because those channels are the likely source of the heat. At the second trip level, it switches off every channel. A channel that has been switched off stays off until a sample falls strictly below the resume level; only then are all channels released together. A test input suppresses the second stage and leaves the first stage working. After reset the block takes no action until the first valid sample arrives.

Top module: `thermal_shed`

## Requirements
- R1: After reset, every disable output (`dig_off`, `cur_off`, `volt_off`) and `ot_flag` are 0.
- R2: When a valid sample is at or above `lvl_trip1`, every channel whose `*_nosat` bit is 1 is disabled from the next cycle on. Channels whose `*_nosat` bit is 0 stay enabled unless the second stage is active.
- R3: The first stage compares with greater-or-equal. A sample equal to `lvl_trip1` trips it, and a sample of `lvl_trip1`-1 does not.
- R4: A channel disabled by the first stage stays disabled after its `*_nosat` bit returns to 0. If the last valid sample was at or above `lvl_trip1`, a channel whose `*_nosat` bit rises is disabled on the following cycle, with no new sample needed.
- R5: When a valid sample is at or above `lvl_trip2` and `stage2_inhibit` is 0, all channels are disabled from the next cycle on, whatever the `*_nosat` bits are. They stay disabled for samples at or above `lvl_resume`.
- R6: A valid sample strictly below `lvl_resume` releases all channels on the next cycle. A sample equal to `lvl_resume`, or between `lvl_resume` and `lvl_trip1`, releases nothing.
- R7: While `stage2_inhibit` is 1, the second stage neither trips nor stays active; raising the input ends an active second stage on the next cycle. The first stage keeps working during this time.
- R8: `ot_flag` is 1 exactly when at least one channel is disabled.
- R9: Until the first valid sample after reset, no channel is disabled, whatever the values of `temp_code` and the `*_nosat` bits. `temp_code` is ignored in any cycle where `temp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_code | input | 8 | Die temperature code |
| temp_vld | input | 1 | Sample-valid strobe for temp_code |
| lvl_trip1 | input | 8 | First-stage trip level |
| lvl_trip2 | input | 8 | Second-stage trip level |
| lvl_resume | input | 8 | Resume level |
| stage2_inhibit | input | 1 | Test control; suppresses the second stage |
| dig_nosat | input | N_DIG | Digital channel cannot saturate |
| cur_nosat | input | N_CUR | Current channel cannot saturate |
| volt_nosat | input | N_VOLT | Voltage channel cannot saturate |
| dig_off | output | N_DIG | Digital channel disable |
| cur_off | output | N_CUR | Current channel disable |
| volt_off | output | N_VOLT | Voltage channel disable |
| ot_flag | output | 1 | Any shutdown in effect |

## Verification
The temperature is stepped across each threshold and held at its edges (trip1-1, trip1, trip2-1, trip2, resume, resume-1). This separates greater-or-equal comparisons from strict ones and shows the hysteresis band. Saturation patterns mix asserted and idle bits across all three channel groups. This shows that the first stage disables only the flagged channels and the second stage disables all of them. Saturation bits are also changed between samples, which separates latched shutdowns from ones that follow the input directly. Hot samples with the inhibit input raised, and the inhibit raised during an active second stage, separate the two stages. Strobe-less hot inputs show that nothing happens before the first valid sample.

// File: rtl/thermal_shed.sv
module thermal_shed #(
  parameter int TW     = 8,
  parameter int N_DIG  = 4,
  parameter int N_CUR  = 2,
  parameter int N_VOLT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     temp_code,
  input  logic              temp_vld,
  input  logic [TW-1:0]     lvl_trip1,
  input  logic [TW-1:0]     lvl_trip2,
  input  logic [TW-1:0]     lvl_resume,
  input  logic              stage2_inhibit,
  input  logic [N_DIG-1:0]  dig_nosat,
  input  logic [N_CUR-1:0]  cur_nosat,
  input  logic [N_VOLT-1:0] volt_nosat,
  output logic [N_DIG-1:0]  dig_off,
  output logic [N_CUR-1:0]  cur_off,
  output logic [N_VOLT-1:0] volt_off,
  output logic              ot_flag
);
  localparam int NCH = N_DIG + N_CUR + N_VOLT;

  logic [NCH-1:0] nosat_all, ch_lat, off_all;
  logic           hot1_q, s2_lat;
  logic           at_trip1, at_trip2, below_res, trip1_now, resume_now;

  assign nosat_all  = {volt_nosat, cur_nosat, dig_nosat};
  assign at_trip1   = temp_code >= lvl_trip1;
  assign at_trip2   = temp_code >= lvl_trip2;
  assign below_res  = temp_code <  lvl_resume;
  assign resume_now = temp_vld && below_res;
  assign trip1_now  = temp_vld ? at_trip1 : hot1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot1_q <= 1'b0;
      ch_lat <= '0;
      s2_lat <= 1'b0;
    end else begin
      if (temp_vld) hot1_q <= at_trip1;
      if (resume_now) ch_lat <= '0;
      else            ch_lat <= ch_lat | (nosat_all & {NCH{trip1_now}});
      if (stage2_inhibit)          s2_lat <= 1'b0;
      else if (resume_now)         s2_lat <= 1'b0;
      else if (temp_vld && at_trip2) s2_lat <= 1'b1;
    end
  end

  assign off_all  = s2_lat ? {NCH{1'b1}} : ch_lat;
  assign dig_off  = off_all[N_DIG-1:0];
  assign cur_off  = off_all[N_DIG +: N_CUR];
  assign volt_off = off_all[N_DIG+N_CUR +: N_VOLT];
  assign ot_flag  = |off_all;

  AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    resume_now |=> (ot_flag == 1'b0)); // R6

  AST_STAGE2_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && at_trip2 && !below_res && !stage2_inhibit) |=>
      (&dig_off && &cur_off && &volt_off)); // R5

  AST_STAGE1_FLAGGED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && at_trip1 && !below_res) |=>
      (({volt_off, cur_off, dig_off} & $past(nosat_all)) == $past(nosat_all))); // R2

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_vld && !stage2_inhibit) |=>
      (($past({volt_off, cur_off, dig_off}) & ~{volt_off, cur_off, dig_off}) == '0)); // R4

  AST_QUIET_UNTIL_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ot_flag) |-> ($past(temp_vld) || $past(hot1_q))); // R9

  AST_INHIBIT_NO_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_inhibit |=> (({volt_off, cur_off, dig_off} & ~$past(ch_lat | nosat_all)) == '0)); // R7
endmodule

// File: tb/thermal_shed_test.sv
module thermal_shed_test;
  localparam int ND = 4, NC = 2, NV = 2;
  localparam logic [7:0] T1 = 8'd100, T2 = 8'd140, TR = 8'd80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] temp_code = '0;
  logic temp_vld = 1'b0;
  logic stage2_inhibit = 1'b0;
  logic [ND-1:0] dig_nosat = '0;
  logic [NC-1:0] cur_nosat = '0;
  logic [NV-1:0] volt_nosat = '0;
  logic [ND-1:0] dig_off;
  logic [NC-1:0] cur_off;
  logic [NV-1:0] volt_off;
  logic ot_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  thermal_shed #(.TW(8), .N_DIG(ND), .N_CUR(NC), .N_VOLT(NV)) uut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_vld(temp_vld),
    .lvl_trip1(T1), .lvl_trip2(T2), .lvl_resume(TR),
    .stage2_inhibit(stage2_inhibit),
    .dig_nosat(dig_nosat), .cur_nosat(cur_nosat), .volt_nosat(volt_nosat),
    .dig_off(dig_off), .cur_off(cur_off), .volt_off(volt_off), .ot_flag(ot_flag)
  );

  // observed = {dig_off, cur_off, volt_off, ot_flag}
  task automatic chk(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {dig_off, cur_off, volt_off, ot_flag};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic sample(input logic [7:0] t);
    @(negedge clk);
    temp_code = t;
    temp_vld  = 1'b1;
    @(negedge clk);
    temp_vld  = 1'b0;
  endtask

  task automatic set_nosat(input logic [ND-1:0] d, input logic [NC-1:0] c, input logic [NV-1:0] v);
    dig_nosat = d; cur_nosat = c; volt_nosat = v;
  endtask

  task automatic t_reset;
    chk("R1 reset state", 9'b0);
  endtask

  task automatic t_quiet;
    set_nosat('1, '1, '1);
    temp_code = 8'd255;
    repeat (4) @(negedge clk);
    chk("R9 no action before first sample", 9'b0);
    temp_code = 8'd0;
    @(negedge clk);
    chk("R9 temp ignored without strobe", 9'b0);
    set_nosat('0, '0, '0);
  endtask

  task automatic t_stage1;
    set_nosat(4'b0101, 2'b10, 2'b00);
    sample(T1 - 8'd1);
    chk("R3 one below trip1", 9'b0);
    sample(T1);
    chk("R2 R3 at trip1 flagged off", {4'b0101, 2'b10, 2'b00, 1'b1});
    chk("R8 flag with stage one", {4'b0101, 2'b10, 2'b00, 1'b1});
  endtask

  task automatic t_latch;
    set_nosat('0, '0, '0);
    @(negedge clk);
    chk("R4 held after nosat clears", {4'b0101, 2'b10, 2'b00, 1'b1});
    volt_nosat = 2'b01;
    @(negedge clk);
    chk("R4 late nosat trips without sample", {4'b0101, 2'b10, 2'b01, 1'b1});
    volt_nosat = 2'b00;
  endtask

  task automatic t_restart;
    sample(TR);
    chk("R6 equal to resume holds", {4'b0101, 2'b10, 2'b01, 1'b1});
    sample(8'd90);
    chk("R6 inside band holds", {4'b0101, 2'b10, 2'b01, 1'b1});
    sample(TR - 8'd1);
    chk("R6 below resume releases", 9'b0);
  endtask

  task automatic t_stage2;
    set_nosat('0, '0, '0);
    sample(T2 - 8'd1);
    chk("R5 one below trip2", 9'b0);
    sample(T2);
    chk("R5 at trip2 all off", 9'h1FF);
    sample(8'd120);
    chk("R5 stays off above resume", 9'h1FF);
    sample(TR - 8'd1);
    chk("R6 R8 release after stage two", 9'b0);
  endtask

  task automatic t_inhibit;
    stage2_inhibit = 1'b1;
    set_nosat(4'b0000, 2'b01, 2'b00);
    sample(8'd200);
    chk("R7 inhibit keeps stage one only", {4'b0000, 2'b01, 2'b00, 1'b1});
    sample(TR - 8'd1);
    stage2_inhibit = 1'b0;
    sample(8'd150);
    chk("R5 stage two before inhibit", 9'h1FF);
    stage2_inhibit = 1'b1;
    @(negedge clk);
    chk("R7 inhibit ends stage two", {4'b0000, 2'b01, 2'b00, 1'b1});
    set_nosat('0, '0, '0);
    sample(TR - 8'd1);
    stage2_inhibit = 1'b0;
    chk("R6 final release", 9'b0);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_stage1();
    t_latch();
    t_restart();
    t_stage2();
    t_inhibit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule